// File: doc/BRIEF.md
# Programmable Probe Trigger Evaluator

This block watches a set of equal-width probe buses and raises a single registered trigger strobe whenever any probe meets its own condition. Each probe owns one condition slot holding a 4-bit operation code and a comparison constant as wide as the probe. The slots are loaded at run time through a small write port, so the trigger can be retargeted without rebuilding the design. A capture engine placed next to it would use the strobe to decide when to start storing samples.

There are two kinds of operation. Some compare the probe against the programmed constant. Others compare the probe against its own value one cycle earlier, which the block keeps in a history register. All arithmetic is unsigned. The strobe is the OR of the per-probe results. It is registered, so it rises on the clock edge that samples the probe values causing it.

Top module: `trig_evaluator`

## Requirements
- R1: While `rst` is high, `trigHit` is low after every clock edge, whatever the probes and conditions are. Condition slots are not cleared by reset and can be written while reset is asserted.
- R2: A write (`cfgWe` high at an edge) with `cfgSel` below NUM_PROBES loads `cfgOp` and `cfgArg` into that probe's slot. The new condition first applies to the probe values sampled at the following edge. A write with `cfgSel` at or above NUM_PROBES changes no slot.
- R3: Code 1 hits when probe > argument. Code 2 hits when probe < argument.
- R4: Code 3 hits when probe >= argument. Code 4 hits when probe <= argument. Both hit at equality.
- R5: Code 5 hits when probe == argument. Code 6 hits when probe != argument.
- R6: Code 7 hits when the probe is greater than its value sampled at the previous edge.
- R7: Code 8 hits when the probe is less than its value sampled at the previous edge.
- R8: Code 9 hits when the probe differs from its value sampled at the previous edge.
- R9: At the first edge after reset is released, codes 7, 8 and 9 do not hit, because no previous sample is valid yet. Codes 1 to 6 are evaluated normally at that edge.
- R10: `trigHit` is the OR over all probes. Code 0 and the unused codes 10 to 15 never contribute.
- R11: `trigHit` changes only at a clock edge and reflects the probe values present just before that edge. A probe change between edges is not visible until the next edge.
- R12: Probe and argument are unsigned, so 0xFF is greater than 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfgWe | input | 1 | Condition slot write strobe |
| cfgSel | input | SEL_W | Index of the probe slot to write |
| cfgOp | input | 4 | Operation code to load |
| cfgArg | input | PROBE_W | Comparison constant to load |
| probes | input | NUM_PROBES*PROBE_W | Packed probe values, probe 0 in the low bits |
| trigHit | output | 1 | Registered trigger strobe |

## Verification
The checker assumes that `cfgWe`, `cfgSel` and the probe bus are driven to known values once reset is released. It also assumes that every slot has been written at least once before the strobe is relied on, because slots power up undefined. The bench meets both assumptions by writing code 0 to every slot while reset is still asserted. It changes inputs only one time unit after a rising edge and holds them until the next edge, including during a reset pulse given in the middle of the run.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_OFF  = 4'd0,
    OP_GT   = 4'd1,
    OP_LT   = 4'd2,
    OP_GE   = 4'd3,
    OP_LE   = 4'd4,
    OP_EQ   = 4'd5,
    OP_NE   = 4'd6,
    OP_RISE = 4'd7,
    OP_FALL = 4'd8,
    OP_CHG  = 4'd9
  } trig_op_e;

  typedef struct packed {
    logic load;       // accepted slot write this cycle
    logic histValid;  // history register holds a real sample
  } trig_ctrl_t;
endpackage

// File: rtl/trig_ctrl.sv
module trig_ctrl
  import trig_pkg::*;
#(
  parameter int unsigned NUM_PROBES = 3,
  parameter int unsigned SEL_W      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgWe,
  input  logic [SEL_W-1:0] cfgSel,
  output trig_ctrl_t       ctrl
);
  localparam logic [SEL_W:0] SEL_LIMIT = (SEL_W+1)'(NUM_PROBES);

  logic histValid;

  // Slot writes are accepted in or out of reset; out-of-range indices drop.
  always_comb begin
    ctrl.load      = cfgWe && ({1'b0, cfgSel} < SEL_LIMIT);
    ctrl.histValid = histValid;
  end

  always_ff @(posedge clk) begin
    if (rst) histValid <= 1'b0;
    else     histValid <= 1'b1;
  end
endmodule

// File: rtl/trig_datapath.sv
module trig_datapath
  import trig_pkg::*;
#(
  parameter int unsigned NUM_PROBES = 3,
  parameter int unsigned PROBE_W    = 8,
  parameter int unsigned SEL_W      = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  trig_ctrl_t                    ctrl,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [OP_W-1:0]               cfgOp,
  input  logic [PROBE_W-1:0]            cfgArg,
  input  logic [NUM_PROBES*PROBE_W-1:0] probes,
  output logic [NUM_PROBES*OP_W-1:0]    opBus,
  output logic                          trigHit
);
  logic [NUM_PROBES*PROBE_W-1:0] prevProbes;
  logic [NUM_PROBES-1:0]         condVec;

  always_ff @(posedge clk) prevProbes <= probes;

  for (genvar g = 0; g < NUM_PROBES; g++) begin : gSlot
    logic [OP_W-1:0]    opReg;
    logic [PROBE_W-1:0] argReg;
    logic [PROBE_W-1:0] curVal;
    logic [PROBE_W-1:0] oldVal;
    logic               slotHit;

    assign curVal = probes[g*PROBE_W +: PROBE_W];
    assign oldVal = prevProbes[g*PROBE_W +: PROBE_W];

    always_ff @(posedge clk) begin
      if (ctrl.load && (cfgSel == SEL_W'(g))) begin
        opReg  <= cfgOp;
        argReg <= cfgArg;
      end
    end

    always_comb begin
      case (opReg)
        OP_GT:   slotHit = curVal >  argReg;
        OP_LT:   slotHit = curVal <  argReg;
        OP_GE:   slotHit = curVal >= argReg;
        OP_LE:   slotHit = curVal <= argReg;
        OP_EQ:   slotHit = curVal == argReg;
        OP_NE:   slotHit = curVal != argReg;
        OP_RISE: slotHit = ctrl.histValid && (curVal > oldVal);
        OP_FALL: slotHit = ctrl.histValid && (curVal < oldVal);
        OP_CHG:  slotHit = ctrl.histValid && (curVal != oldVal);
        default: slotHit = 1'b0;
      endcase
    end

    assign condVec[g]                = slotHit;
    assign opBus[g*OP_W +: OP_W]     = opReg;
  end

  always_ff @(posedge clk) begin
    if (rst) trigHit <= 1'b0;
    else     trigHit <= |condVec;
  end
endmodule

// File: rtl/trig_evaluator.sv
module trig_evaluator
  import trig_pkg::*;
#(
  parameter int unsigned NUM_PROBES = 3,
  parameter int unsigned PROBE_W    = 8,
  localparam int unsigned SEL_W     = (NUM_PROBES > 1) ? $clog2(NUM_PROBES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfgWe,
  input  logic [SEL_W-1:0]              cfgSel,
  input  logic [3:0]                    cfgOp,
  input  logic [PROBE_W-1:0]            cfgArg,
  input  logic [NUM_PROBES*PROBE_W-1:0] probes,
  output logic                          trigHit
);
  trig_ctrl_t                     ctrl;
  logic [NUM_PROBES*OP_W-1:0]     opBus;

  trig_ctrl #(.NUM_PROBES(NUM_PROBES), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .ctrl(ctrl)
  );

  trig_datapath #(.NUM_PROBES(NUM_PROBES), .PROBE_W(PROBE_W), .SEL_W(SEL_W)) i_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .cfgSel(cfgSel), .cfgOp(cfgOp),
    .cfgArg(cfgArg), .probes(probes), .opBus(opBus), .trigHit(trigHit)
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int unsigned NUM_PROBES = 3,
  parameter int unsigned SEL_W      = 2,
  parameter int unsigned OP_W       = 4
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       cfgWe,
  input logic [SEL_W-1:0]           cfgSel,
  input logic [NUM_PROBES*OP_W-1:0] opBus,
  input logic                       histValid,
  input logic                       trigHit
);
  logic [NUM_PROBES-1:0] liveSlot;

  always_comb begin
    for (int i = 0; i < NUM_PROBES; i++) begin
      liveSlot[i] = (opBus[i*OP_W +: OP_W] != '0) &&
                    (opBus[i*OP_W +: OP_W] <= OP_W'(9));
    end
  end

  AST_HIT_NEEDS_LIVE_SLOT: assert property (@(posedge clk) disable iff (rst)
    trigHit |-> $past(|liveSlot));                                     // R10
  AST_HISTORY_INVALID_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !histValid);                                        // R9
  AST_SLOTS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cfgWe |=> $stable(opBus));                                        // R2
  AST_BAD_INDEX_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (cfgWe && ({1'b0, cfgSel} >= (SEL_W+1)'(NUM_PROBES))) |=> $stable(opBus)); // R2
  AST_HIT_KNOWN: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(trigHit));                                             // R11
endmodule

bind trig_evaluator trig_checker #(
  .NUM_PROBES(NUM_PROBES), .SEL_W(SEL_W), .OP_W(4)
) i_trig_checker (
  .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel),
  .opBus(opBus), .histValid(ctrl.histValid), .trigHit(trigHit)
);

// File: tb/test_trig_evaluator.sv
module test_trig_evaluator;
  localparam int NP = 3;
  localparam int PW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgSel = '0;
  logic [3:0]    cfgOp = '0;
  logic [PW-1:0] cfgArg = '0;
  logic [PW-1:0] pv0 = '0, pv1 = '0, pv2 = '0;
  logic          trigHit;
  int            nChecks = 0;
  int            nFails = 0;

  always #4 clk = ~clk;

  trig_evaluator #(.NUM_PROBES(NP), .PROBE_W(PW)) i_trig_evaluator (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgOp(cfgOp),
    .cfgArg(cfgArg), .probes({pv2, pv1, pv0}), .trigHit(trigHit)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: trigHit=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic writeSlot(input logic [1:0] sel, input logic [3:0] op, input logic [PW-1:0] arg);
    cfgWe = 1'b1; cfgSel = sel; cfgOp = op; cfgArg = arg;
    tick();
    cfgWe = 1'b0;
  endtask

  task automatic clearAll();
    for (int i = 0; i < NP; i++) writeSlot(2'(i), 4'd0, '0);
  endtask

  // R1: hold reset, slots written while in reset
  task automatic testReset();
    clearAll();
    pv0 = 8'h11; tick();
    check("R1", trigHit, 1'b0);
    rst = 1'b0;
  endtask

  // R10: disabled and unused codes never hit
  task automatic testDisabled();
    clearAll();
    pv0 = 8'h00; pv1 = 8'hFF; tick();
    pv0 = 8'h80; pv1 = 8'h00; tick();
    check("R10 code0", trigHit, 1'b0);
    writeSlot(2'd0, 4'd12, 8'h80);
    pv0 = 8'h80; tick(); pv0 = 8'h81; tick();
    check("R10 code12", trigHit, 1'b0);
  endtask

  // R3, R12
  task automatic testGtLt();
    writeSlot(2'd0, 4'd1, 8'h40);
    pv0 = 8'h41; tick(); check("R3 gt", trigHit, 1'b1);
    pv0 = 8'h40; tick(); check("R3 gt eq", trigHit, 1'b0);
    writeSlot(2'd0, 4'd2, 8'h40);
    pv0 = 8'h3F; tick(); check("R3 lt", trigHit, 1'b1);
    pv0 = 8'h40; tick(); check("R3 lt eq", trigHit, 1'b0);
    writeSlot(2'd0, 4'd1, 8'h01);
    pv0 = 8'hFF; tick(); check("R12 unsigned", trigHit, 1'b1);
  endtask

  // R4
  task automatic testGeLe();
    writeSlot(2'd0, 4'd3, 8'h80);
    pv0 = 8'h80; tick(); check("R4 ge eq", trigHit, 1'b1);
    pv0 = 8'h7F; tick(); check("R4 ge below", trigHit, 1'b0);
    writeSlot(2'd0, 4'd4, 8'h10);
    pv0 = 8'h10; tick(); check("R4 le eq", trigHit, 1'b1);
    pv0 = 8'h11; tick(); check("R4 le above", trigHit, 1'b0);
  endtask

  // R5
  task automatic testEqNe();
    writeSlot(2'd0, 4'd5, 8'hA5);
    pv0 = 8'hA5; tick(); check("R5 eq", trigHit, 1'b1);
    pv0 = 8'hA4; tick(); check("R5 eq miss", trigHit, 1'b0);
    writeSlot(2'd0, 4'd6, 8'hA5);
    pv0 = 8'hA5; tick(); check("R5 ne miss", trigHit, 1'b0);
    pv0 = 8'h00; tick(); check("R5 ne", trigHit, 1'b1);
  endtask

  // R6, R7, R8
  task automatic testEdges();
    writeSlot(2'd0, 4'd7, '0);
    pv0 = 8'h10; tick(); pv0 = 8'h20; tick(); check("R6 rise", trigHit, 1'b1);
    tick(); check("R6 steady", trigHit, 1'b0);
    pv0 = 8'h05; tick(); check("R6 drop", trigHit, 1'b0);
    pv0 = 8'h01; tick(); pv0 = 8'hF0; tick(); check("R6 rise wide", trigHit, 1'b1);
    writeSlot(2'd0, 4'd8, '0);
    pv0 = 8'h20; tick(); pv0 = 8'h10; tick(); check("R7 fall", trigHit, 1'b1);
    tick(); check("R7 steady", trigHit, 1'b0);
    pv0 = 8'h30; tick(); check("R7 rise", trigHit, 1'b0);
    writeSlot(2'd0, 4'd9, '0);
    pv0 = 8'h03; tick(); tick(); check("R8 steady", trigHit, 1'b0);
    pv0 = 8'h04; tick(); check("R8 change", trigHit, 1'b1);
  endtask

  // R11
  task automatic testLatency();
    writeSlot(2'd0, 4'd5, 8'h33);
    pv0 = 8'h00; tick();
    pv0 = 8'h33; #1; check("R11 before edge", trigHit, 1'b0);
    tick(); check("R11 at edge", trigHit, 1'b1);
    pv0 = 8'h00; #1; check("R11 held", trigHit, 1'b1);
    tick(); check("R11 cleared", trigHit, 1'b0);
  endtask

  // R10: OR across probes
  task automatic testOr();
    clearAll();
    writeSlot(2'd0, 4'd5, 8'h01);
    writeSlot(2'd1, 4'd5, 8'h02);
    pv0 = 8'h01; pv1 = 8'h00; pv2 = 8'h55; tick(); check("R10 p0", trigHit, 1'b1);
    pv0 = 8'h00; pv1 = 8'h02; tick(); check("R10 p1", trigHit, 1'b1);
    pv1 = 8'h00; pv2 = 8'hAA; tick(); check("R10 none", trigHit, 1'b0);
  endtask

  // R2: addressing and when a write takes effect
  task automatic testSelect();
    clearAll();
    pv0 = 8'h00; pv1 = 8'h00; pv2 = 8'h00;
    writeSlot(2'd3, 4'd5, 8'h00);
    tick(); check("R2 bad index", trigHit, 1'b0);
    writeSlot(2'd2, 4'd5, 8'h00);
    check("R2 not yet live", trigHit, 1'b0);
    tick(); check("R2 live", trigHit, 1'b1);
  endtask

  // R1, R9: mid-run reset
  task automatic testFirstCycle();
    clearAll();
    writeSlot(2'd0, 4'd9, '0);
    pv0 = 8'h05; tick();
    rst = 1'b1; pv0 = 8'h07; tick(); check("R1 in reset", trigHit, 1'b0);
    tick();
    pv0 = 8'h09; rst = 1'b0; tick(); check("R9 first edge", trigHit, 1'b0);
    tick(); check("R8 stable", trigHit, 1'b0);
    pv0 = 8'h03; tick(); check("R9 history live", trigHit, 1'b1);
  endtask

  initial begin
    #(200000 * 8);
    nFails++;
    nChecks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    tick();
    testReset();
    testDisabled();
    testGtLt();
    testGeLe();
    testEqNe();
    testEdges();
    testLatency();
    testOr();
    testSelect();
    testFirstCycle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule